// File: doc/BRIEF.md
# ATA PIO Timing Count Encoder

This block converts the nanosecond timing of one PIO transfer (address setup time, strobe active time and total cycle time) into bus-clock counts for a single drive. It then packs them into the two byte fields a strobe generator expects: an address-setup byte and a read/write timing byte. A request gives the times, the bus clock period in nanoseconds, a channel select and a drive select. A one-cycle `start` pulse begins the work, and a one-cycle `done` pulse marks the moment the counts and the register bytes are updated.

Each count is a rounded-up quotient, formed on one shared sequential divider. The recovery count must be long enough for the whole cycle. Recovery that exceeds the field's reach is moved into the active phase, and the active phase is then capped. The primary channel keeps one setup byte per drive. The secondary channel keeps a single setup byte for both drives. That byte always holds the encoding of the slower of the two drives' latest setup counts, so reprogramming either drive recomputes it.

Top module: `pio_timing_encoder`

## Requirements
- R1: After reset, all three setup bytes read 0x40, all four timing bytes read 0x3F, and `busy` and `done` are low.
- R2: A `start` pulse seen while idle raises `busy` in the following cycle. `done` pulses for exactly one cycle no more than 4*(NS_W+3)+6 cycles after the start edge. A `start` pulse seen while busy is ignored, so the results are those of the accepted request.
- R3: The setup, active and cycle counts are ceil(time / clock period), with the clock period at least 1. The raw recovery count is ceil(recovery time / clock period), where recovery time is cycle − setup − active, floored at 0.
- R4: The recovery count is the larger of the raw recovery count and (cycle count − setup count − active count), the latter floored at 0.
- R5: If the recovery count exceeds 16, the excess is added to the active count and recovery becomes 16. After that, the active count is limited to 16. `cnt_active` and `cnt_recovery` report the final values.
- R6: The timing byte at index 2*chan_sel+drive_sel takes the low four bits of the active count in bits 7:4. Bits 3:0 take a recovery code: counts 0 and 1 give 15, counts 2 to 15 give count−1, and count 16 gives 0.
- R7: Bits 7:6 of a written setup byte take a setup code: counts 0 to 2 give 01b, count 3 gives 10b, count 4 gives 00b, and counts of 5 or more give 11b. Bits 5:0 are never altered.
- R8: On the primary channel (chan_sel=0), setup byte index drive_sel is written from that drive's own setup count.
- R9: On the secondary channel (chan_sel=1), the requesting drive's setup count is stored, and setup byte index 2 is written from the larger of the two stored secondary counts. Both stored counts reset to 0.
- R10: Only the setup byte and the timing byte selected by the request change, and only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, latched with the operands when idle |
| chan_sel | input | 1 | 0 primary channel, 1 secondary channel |
| drive_sel | input | 1 | Drive within the channel |
| setup_ns | input | NS_W | Address setup time in ns |
| active_ns | input | NS_W | Strobe active time in ns |
| cycle_ns | input | NS_W | Total cycle time in ns |
| clk_period_ns | input | CLK_W | Bus clock period in ns, at least 1 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse, results updated |
| cnt_setup | output | NS_W | Setup count of the last request |
| cnt_active | output | 5 | Final active count of the last request |
| cnt_recovery | output | 5 | Final recovery count of the last request |
| setup_bytes | output | 3x8 | Setup bytes: primary drive 0, primary drive 1, shared secondary |
| timing_bytes | output | 4x8 | Timing bytes indexed 2*channel+drive |

## Verification
The assertions check on every cycle the properties that hold regardless of the data: `done` is a single-cycle pulse that follows a busy cycle, a request never stays busy beyond the latency bound, the low six bits of every setup byte stay constant, register bytes move only with `done`, and the final active and recovery counts never exceed 16. The arithmetic can only be shown by the bench scenarios, which compare the counts and all seven bytes against a model. This covers the rounding, the cycle-length constraint, the spill of recovery into the active phase, both encodings at their edge values, the secondary merge as either drive is reprogrammed, and a start that arrives while busy.

// File: rtl/pio_enc_pkg.sv
package pio_enc_pkg;

    localparam int          PHASE_MAX   = 16;
    localparam int          SETUP_SAT   = 5;
    localparam logic [7:0]  SETUP_RST   = 8'h40;
    localparam logic [7:0]  TIMING_RST  = 8'h3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_RESOLVE,
        ST_COMMIT
    } ctrl_state_e;

    typedef struct packed {
        logic chan;
        logic drive;
    } target_t;

    // Two-bit address-setup code from a count already saturated at 5.
    function automatic logic [1:0] enc_setup(input logic [2:0] cnt);
        logic [1:0] code;
        case (cnt)
            3'd3:                code = 2'b10;
            3'd4:                code = 2'b00;
            3'd5, 3'd6, 3'd7:    code = 2'b11;
            default:             code = 2'b01;
        endcase
        return code;
    endfunction

    // Four-bit recovery code from a count in 0..16.
    function automatic logic [3:0] enc_recovery(input logic [4:0] cnt);
        logic [3:0] code;
        if (cnt <= 5'd1)
            code = 4'hF;
        else if (cnt >= 5'(PHASE_MAX))
            code = 4'h0;
        else
            code = 4'(cnt - 5'd1);
        return code;
    endfunction

endpackage

// File: rtl/seq_ceil_div.sv
module seq_ceil_div #(
    parameter int N = 10,
    parameter int D = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         done,
    output logic [N-1:0] result
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  dvd_q;
    logic [N-1:0]  quo_q;
    logic [D:0]    rem_q;
    logic [D-1:0]  dvs_q;
    logic [CW-1:0] step_q;
    logic          run_q;

    logic [D:0]    rem_sh;
    logic          fits;
    logic [D:0]    rem_nx;

    always_comb begin
        rem_sh = {rem_q[D-1:0], dvd_q[N-1]};
        fits   = (rem_sh >= {1'b0, dvs_q});
        rem_nx = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run_q) begin
                dvd_q  <= dividend;
                dvs_q  <= divisor;
                quo_q  <= '0;
                rem_q  <= '0;
                step_q <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                dvd_q  <= dvd_q << 1;
                quo_q  <= {quo_q[N-2:0], fits};
                rem_q  <= rem_nx;
                step_q <= step_q + 1'b1;
                if (step_q == CW'(N - 1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    // A nonzero remainder rounds the quotient up.
    assign result = quo_q + {{(N-1){1'b0}}, |rem_q};

endmodule

// File: rtl/pio_count_ctrl.sv
module pio_count_ctrl
    import pio_enc_pkg::*;
#(
    parameter int NS_W  = 10,
    parameter int CLK_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             chan_in,
    input  logic             drive_in,
    input  logic [NS_W-1:0]  setup_ns,
    input  logic [NS_W-1:0]  active_ns,
    input  logic [NS_W-1:0]  cycle_ns,
    input  logic [CLK_W-1:0] clk_ns,
    output logic             busy,
    output logic             commit,
    output target_t          target,
    output logic [NS_W-1:0]  fin_setup,
    output logic [4:0]       fin_active,
    output logic [4:0]       fin_rec
);
    localparam int OPS   = 4;
    localparam int IDX_W = $clog2(OPS);
    localparam int WIDE  = NS_W + 2;
    localparam logic [WIDE-1:0] LIMIT = WIDE'(PHASE_MAX);

    ctrl_state_e       state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [NS_W-1:0]   ops_q [OPS];
    logic [NS_W-1:0]   quo_q [OPS];
    logic [CLK_W-1:0]  clk_q;

    logic [NS_W+1:0]   sum_sa;
    logic [NS_W-1:0]   rec_ns;
    logic              div_done;
    logic [NS_W-1:0]   div_res;

    // Recovery time in ns, floored at zero.
    always_comb begin
        sum_sa = {2'b00, setup_ns} + {2'b00, active_ns};
        rec_ns = ({2'b00, cycle_ns} > sum_sa) ? NS_W'({2'b00, cycle_ns} - sum_sa) : '0;
    end

    seq_ceil_div #(.N(NS_W), .D(CLK_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .start    (state_q == ST_LAUNCH),
        .dividend (ops_q[idx_q]),
        .divisor  (clk_q),
        .done     (div_done),
        .result   (div_res)
    );

    // Cycle constraint, spill of excess recovery, then limits.
    logic [WIDE-1:0] qs, qa, qc, qr, sa, rc2, rc, a_adj;
    logic [4:0]      rc_cl, a_cl;

    always_comb begin
        qs    = WIDE'(quo_q[0]);
        qa    = WIDE'(quo_q[1]);
        qc    = WIDE'(quo_q[2]);
        qr    = WIDE'(quo_q[3]);
        sa    = qs + qa;
        rc2   = (qc > sa) ? (qc - sa) : '0;
        rc    = (rc2 > qr) ? rc2 : qr;
        if (rc > LIMIT) begin
            a_adj = qa + (rc - LIMIT);
            rc_cl = 5'(PHASE_MAX);
        end else begin
            a_adj = qa;
            rc_cl = rc[4:0];
        end
        a_cl = (a_adj > LIMIT) ? 5'(PHASE_MAX) : a_adj[4:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            clk_q      <= '0;
            target     <= '0;
            fin_setup  <= '0;
            fin_active <= '0;
            fin_rec    <= '0;
            for (int i = 0; i < OPS; i++) begin
                ops_q[i] <= '0;
                quo_q[i] <= '0;
            end
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ops_q[0]     <= setup_ns;
                        ops_q[1]     <= active_ns;
                        ops_q[2]     <= cycle_ns;
                        ops_q[3]     <= rec_ns;
                        clk_q        <= clk_ns;
                        target.chan  <= chan_in;
                        target.drive <= drive_in;
                        idx_q        <= '0;
                        state_q      <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (div_done) begin
                        quo_q[idx_q] <= div_res;
                        if (idx_q == IDX_W'(OPS - 1)) begin
                            state_q <= ST_RESOLVE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_LAUNCH;
                        end
                    end
                end
                ST_RESOLVE: begin
                    fin_setup  <= quo_q[0];
                    fin_active <= a_cl;
                    fin_rec    <= rc_cl;
                    state_q    <= ST_COMMIT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign commit = (state_q == ST_COMMIT);

endmodule

// File: rtl/pio_reg_bank.sv
module pio_reg_bank
    import pio_enc_pkg::*;
#(
    parameter int NS_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  target_t         target,
    input  logic [NS_W-1:0] fin_setup,
    input  logic [3:0]      active_nib,
    input  logic [4:0]      fin_rec,
    output logic            done,
    output logic [2:0][7:0] setup_bytes,
    output logic [3:0][7:0] timing_bytes
);
    localparam int PRI_DRIVES = 2;
    localparam int TIM_REGS   = 4;

    logic [7:0]      pri_q [PRI_DRIVES];
    logic [7:0]      sec_q;
    logic [7:0]      tim_q [TIM_REGS];
    logic [NS_W-1:0] sec_cnt [2];

    logic [NS_W-1:0] other_cnt, merged_cnt;
    logic [2:0]      own_sat, merged_sat;
    logic [7:0]      tim_word;

    function automatic logic [2:0] sat_setup(input logic [NS_W-1:0] c);
        return (c > NS_W'(SETUP_SAT)) ? 3'(SETUP_SAT) : c[2:0];
    endfunction

    always_comb begin
        other_cnt  = target.drive ? sec_cnt[0] : sec_cnt[1];
        merged_cnt = (fin_setup > other_cnt) ? fin_setup : other_cnt;
        own_sat    = sat_setup(fin_setup);
        merged_sat = sat_setup(merged_cnt);
        tim_word   = {active_nib, enc_recovery(fin_rec)};
    end

    for (genvar g = 0; g < PRI_DRIVES; g++) begin : g_pri
        always_ff @(posedge clk) begin
            if (rst)
                pri_q[g] <= SETUP_RST;
            else if (commit && !target.chan && (target.drive == g[0]))
                pri_q[g] <= {enc_setup(own_sat), pri_q[g][5:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q      <= SETUP_RST;
            sec_cnt[0] <= '0;
            sec_cnt[1] <= '0;
        end else if (commit && target.chan) begin
            sec_cnt[target.drive] <= fin_setup;
            sec_q <= {enc_setup(merged_sat), sec_q[5:0]};
        end
    end

    for (genvar g = 0; g < TIM_REGS; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[g] <= TIMING_RST;
            else if (commit && ({target.chan, target.drive} == 2'(g)))
                tim_q[g] <= tim_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= commit;
    end

    always_comb begin
        setup_bytes[0] = pri_q[0];
        setup_bytes[1] = pri_q[1];
        setup_bytes[2] = sec_q;
        for (int i = 0; i < TIM_REGS; i++) timing_bytes[i] = tim_q[i];
    end

endmodule

// File: rtl/pio_timing_encoder.sv
module pio_timing_encoder
    import pio_enc_pkg::*;
#(
    parameter int NS_W  = 10,
    parameter int CLK_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             chan_sel,
    input  logic             drive_sel,
    input  logic [NS_W-1:0]  setup_ns,
    input  logic [NS_W-1:0]  active_ns,
    input  logic [NS_W-1:0]  cycle_ns,
    input  logic [CLK_W-1:0] clk_period_ns,
    output logic             busy,
    output logic             done,
    output logic [NS_W-1:0]  cnt_setup,
    output logic [4:0]       cnt_active,
    output logic [4:0]       cnt_recovery,
    output logic [2:0][7:0]  setup_bytes,
    output logic [3:0][7:0]  timing_bytes
);
    logic    commit;
    target_t target;

    pio_count_ctrl #(.NS_W(NS_W), .CLK_W(CLK_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .chan_in    (chan_sel),
        .drive_in   (drive_sel),
        .setup_ns   (setup_ns),
        .active_ns  (active_ns),
        .cycle_ns   (cycle_ns),
        .clk_ns     (clk_period_ns),
        .busy       (busy),
        .commit     (commit),
        .target     (target),
        .fin_setup  (cnt_setup),
        .fin_active (cnt_active),
        .fin_rec    (cnt_recovery)
    );

    pio_reg_bank #(.NS_W(NS_W)) bank_i (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .target       (target),
        .fin_setup    (cnt_setup),
        .active_nib   (cnt_active[3:0]),
        .fin_rec      (cnt_recovery),
        .done         (done),
        .setup_bytes  (setup_bytes),
        .timing_bytes (timing_bytes)
    );

endmodule

// File: rtl/pio_timing_encoder_chk.sv
module pio_timing_encoder_chk #(
    parameter int NS_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic [4:0]      cnt_active,
    input logic [4:0]      cnt_recovery,
    input logic [2:0][7:0] setup_bytes,
    input logic [3:0][7:0] timing_bytes
);
    localparam int LAT_MAX = 4 * (NS_W + 3) + 6;
    localparam int RUN_W   = $clog2(LAT_MAX + 2) + 1;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RUN_W'(LAT_MAX));

    assert_counts_capped_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_active <= 5'd16 && cnt_recovery <= 5'd16));

    assert_low_bits_kept_R7: assert property (@(posedge clk) disable iff (rst)
        $stable({setup_bytes[2][5:0], setup_bytes[1][5:0], setup_bytes[0][5:0]}));

    assert_timing_moves_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(timing_bytes) |-> done);

    assert_setup_moves_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(setup_bytes) |-> done);

endmodule

bind pio_timing_encoder pio_timing_encoder_chk #(.NS_W(NS_W)) chk_i (.*);

// File: tb/pio_timing_encoder_tb_top.sv
`timescale 1ns/1ps
module pio_timing_encoder_tb_top;
    localparam int NS_W    = 10;
    localparam int CLK_W   = 6;
    localparam int LAT_MAX = 4 * (NS_W + 3) + 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic             chan_sel;
    logic             drive_sel;
    logic [NS_W-1:0]  setup_ns;
    logic [NS_W-1:0]  active_ns;
    logic [NS_W-1:0]  cycle_ns;
    logic [CLK_W-1:0] clk_period_ns;
    logic             busy;
    logic             done;
    logic [NS_W-1:0]  cnt_setup;
    logic [4:0]       cnt_active;
    logic [4:0]       cnt_recovery;
    logic [2:0][7:0]  setup_bytes;
    logic [3:0][7:0]  timing_bytes;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] exp_setup [3];
    logic [7:0] exp_tim   [4];
    int         sec_cnt   [2];

    always #2 clk = ~clk;

    pio_timing_encoder #(.NS_W(NS_W), .CLK_W(CLK_W)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int cdiv(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    function automatic logic [1:0] m_setup_code(input int c);
        if (c <= 2) return 2'b01;
        if (c == 3) return 2'b10;
        if (c == 4) return 2'b00;
        return 2'b11;
    endfunction

    function automatic logic [3:0] m_rec_code(input int c);
        if (c <= 1) return 4'hF;
        if (c >= 16) return 4'h0;
        return 4'(c - 1);
    endfunction

    task automatic check_all_bytes(input string tag);
        for (int i = 0; i < 3; i++) chk({tag, " setup byte"}, int'(setup_bytes[i]), int'(exp_setup[i]));
        for (int i = 0; i < 4; i++) chk({tag, " timing byte"}, int'(timing_bytes[i]), int'(exp_tim[i]));
    endtask

    // One request; with 'poke' a second start with other operands is sent while busy.
    task automatic run_req(input int ch, input int dr, input int s, input int a,
                           input int c, input int ck, input bit poke);
        int qs, qa, qc, qr, rec, rc2, rc, act, lat, m;
        @(negedge clk);
        chan_sel = ch[0]; drive_sel = dr[0];
        setup_ns = NS_W'(s); active_ns = NS_W'(a); cycle_ns = NS_W'(c);
        clk_period_ns = CLK_W'(ck);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        lat = 1;
        if (poke) begin
            @(negedge clk);
            lat++;
            chan_sel = ~chan_sel; drive_sel = ~drive_sel;
            setup_ns = 10'd999; active_ns = 10'd1; cycle_ns = 10'd3; clk_period_ns = 6'd1;
            start = 1'b1;
            @(negedge clk);
            lat++;
            start = 1'b0;
        end
        while (!done && lat <= LAT_MAX + 4) begin
            @(negedge clk);
            lat++;
        end
        chk("R2 done within bound", int'(done && lat <= LAT_MAX), 1);

        // Model of the counts (R3, R4, R5).
        qs  = cdiv(s, ck);
        qa  = cdiv(a, ck);
        qc  = cdiv(c, ck);
        rec = c - s - a;
        if (rec < 0) rec = 0;
        qr  = cdiv(rec, ck);
        rc2 = qc - qs - qa;
        if (rc2 < 0) rc2 = 0;
        rc  = (rc2 > qr) ? rc2 : qr;
        act = qa;
        if (rc > 16) begin
            act = act + rc - 16;
            rc  = 16;
        end
        if (act > 16) act = 16;
        chk("R3 setup count", int'(cnt_setup), qs);
        chk("R4 recovery count", int'(cnt_recovery), rc);
        chk("R5 active count", int'(cnt_active), act);

        // Model of the register bytes (R6..R9).
        exp_tim[ch * 2 + dr] = {4'(act), m_rec_code(rc)};
        if (ch == 0) begin
            exp_setup[dr] = {m_setup_code(qs), exp_setup[dr][5:0]};
        end else begin
            sec_cnt[dr] = qs;
            m = (sec_cnt[0] > sec_cnt[1]) ? sec_cnt[0] : sec_cnt[1];
            exp_setup[2] = {m_setup_code(m), exp_setup[2][5:0]};
        end
        check_all_bytes("R6 R7 R8 R9 R10");
        @(negedge clk);
        chk("R2 done single pulse", int'(done), 0);
        check_all_bytes("R10 held");
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        rst = 1'b1; start = 1'b0; chan_sel = 1'b0; drive_sel = 1'b0;
        setup_ns = '0; active_ns = '0; cycle_ns = '0; clk_period_ns = 6'd1;
        for (int i = 0; i < 3; i++) exp_setup[i] = 8'h40;
        for (int i = 0; i < 4; i++) exp_tim[i] = 8'h3F;
        sec_cnt[0] = 0; sec_cnt[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        check_all_bytes("R1 reset");

        // R3 R4 ordinary primary request
        run_req(0, 0, 30, 290, 600, 30, 0);
        // R5 huge recovery spills into active and caps at 16; setup 5 -> 11b
        run_req(0, 1, 5, 10, 1000, 1, 0);
        // R4 negative recovery time floors at zero; R6 recovery 0 -> 15, active 20 -> 16
        run_req(0, 0, 100, 200, 50, 10, 0);
        // R7 setup count 3, recovery count 2
        run_req(0, 1, 30, 40, 90, 10, 0);
        // R7 setup count 4
        run_req(0, 0, 40, 50, 250, 10, 0);
        // R5 recovery exactly 16 stays, 17 spills one into active
        run_req(0, 1, 10, 50, 220, 10, 0);
        run_req(0, 0, 10, 50, 230, 10, 0);
        // R9 secondary merge: drive 0 count 4, drive 1 count 2, then drive 0 count 1
        run_req(1, 0, 40, 60, 300, 10, 0);
        run_req(1, 1, 20, 60, 300, 10, 0);
        run_req(1, 0, 5, 60, 300, 10, 0);
        // R8 primary drives stay independent
        run_req(0, 1, 60, 80, 400, 10, 0);
        // R2 start during busy is ignored
        run_req(1, 1, 70, 120, 500, 25, 1);

        for (int k = 0; k < 60; k++) begin
            run_req(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                    int'($urandom_range(0, 300)), int'($urandom_range(0, 500)),
                    int'($urandom_range(0, 1023)), int'($urandom_range(1, 50)), 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule